// File: doc/BRIEF.md
# Debounced Matrix Keypad Scanner

This block reads a 4-by-4 matrix keypad from one synchronous clock domain. It pulls one column line low at a time. It samples the four row lines, which are pulled high on the board and arrive asynchronously through a two-stage synchronizer. A low row under the active column marks a closed contact. The scanner locks onto the first contact it finds. It waits until that contact has stayed closed for a full debounce interval, then emits a one-cycle strobe together with a 4-bit hexadecimal code. The code is taken from a parameterized row/column layout map.

While the locked key is held, scanning stops and only the locked column is driven, so no other key can produce an event. The lock is dropped only after the locked row has read open for a full debounce interval. Scanning then resumes. The state machine has four states:

- `ST_SCAN` steps through the columns.
- `ST_DB_PRESS` times the closure.
- `ST_HELD` waits for the contact to open.
- `ST_DB_REL` times the opening.

The state machine has six transitions:

- **hit**: `ST_SCAN` to `ST_DB_PRESS`, when a sampled row is low.
- **bounce-out**: `ST_DB_PRESS` to `ST_SCAN`, when the row opens before the interval ends.
- **accept**: `ST_DB_PRESS` to `ST_HELD`, when the interval completes; the strobe fires here.
- **open**: `ST_HELD` to `ST_DB_REL`, when the row reads high.
- **reclose**: `ST_DB_REL` to `ST_HELD`, when the row reads low again.
- **release**: `ST_DB_REL` to `ST_SCAN`, when the interval completes.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is asserted, `col_n_o` is 4'b1110 (column 0 driven), `key_valid_o` is 0 and `key_code_o` is 0.
- R2: While scanning with no key closed, exactly one column line is low, and the driven column advances 0,1,2,3,0 every SETTLE_CYCLES clocks. Column c low means bit c of `col_n_o` is 0.
- R3: A press is accepted only after the locked row reads low without a break for DEBOUNCE_CYCLES clocks. Contact that keeps breaking sooner gives no strobe.
- R4: On acceptance, `key_valid_o` is high for exactly one clock. `key_code_o` then holds nibble [(row*COLS+col)*4 +: 4] of KEY_MAP. With the default map, rows 0..3 read 1 2 3 A / 4 5 6 B / 7 8 9 C / E 0 F D from column 0 to column 3.
- R5: One physical press yields exactly one strobe, whatever its hold time, including bounce at make and break and short openings during the hold.
- R6: While a key is locked, the driven column stays fixed on the locked column. Other keys, in the same row or the same column, produce no strobe.
- R7: The lock ends only after the locked row reads high for DEBOUNCE_CYCLES clocks. An opening shorter than that followed by reclosure gives no new strobe. After a full release, the next press is reported.
- R8: If several rows are low under the same column when sampled, the lowest-numbered row is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_n_i | input | ROWS | Raw row lines, low when a contact closes to the driven column |
| col_n_o | output | COLS | Column drive lines, active low, one at a time |
| key_valid_o | output | 1 | One-cycle strobe per accepted press |
| key_code_o | output | 4 | Hex code of the accepted key |

## Verification
A keypad model in the bench ties each row to the driven column through a table of closed keys. The block is tried first with clean single presses on keys in every row and column, held for short and long times. These presses separate correct code mapping and once-only reporting from repeat or lost events. Chattering contacts at make, mid-hold and break probe the debounce windows in both directions. Extra keys closed during a hold, in the same row and in the same column, show whether the lock holds. Two rows closed together under one column expose the row priority.

// File: rtl/kps_pkg.sv
package kps_pkg;
    typedef enum logic [1:0] {
        ST_SCAN,
        ST_DB_PRESS,
        ST_HELD,
        ST_DB_REL
    } kps_state_e;
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= '1;   // rows idle high
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/kps_col_scan.sv
module kps_col_scan #(
    parameter int COLS          = 4,
    parameter int SETTLE_CYCLES = 4,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int SW = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,     // advance allowed this cycle
    output logic [CW-1:0] col_idx_o,
    output logic          sample_o   // settle interval complete, rows valid
);
    logic [SW-1:0] settle_q;
    logic [CW-1:0] col_q;

    assign sample_o  = (settle_q == SW'(SETTLE_CYCLES - 1));
    assign col_idx_o = col_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
            col_q    <= '0;
        end else if (!run_i) begin
            settle_q <= '0;
        end else if (sample_o) begin
            settle_q <= '0;
            col_q    <= (col_q == CW'(COLS - 1)) ? '0 : col_q + CW'(1);
        end else begin
            settle_q <= settle_q + SW'(1);
        end
    end

    // R6: a stopped scan never moves the column
    p_col_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> $stable(col_idx_o));

    // R2: settle counter never passes its limit
    p_settle_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        settle_q <= SW'(SETTLE_CYCLES - 1));
endmodule

// File: rtl/kps_ctrl.sv
module kps_ctrl
    import kps_pkg::*;
#(
    parameter int ROWS            = 4,
    parameter int COLS            = 4,
    parameter int DEBOUNCE_CYCLES = 1_000_000,
    parameter logic [ROWS*COLS*4-1:0] KEY_MAP = 64'hDF0E_C987_B654_A321,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DW = $clog2(DEBOUNCE_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] rows_n_i,   // synchronized, active low
    input  logic [CW-1:0]   col_idx_i,
    input  logic            sample_i,
    output logic            run_o,
    output logic            key_valid_o,
    output logic [3:0]      key_code_o
);
    kps_state_e    state_q, state_d;
    logic [DW-1:0] cnt_q;
    logic [RW-1:0] lock_row_q;
    logic [RW-1:0] hit_row;
    logic          any_hit;
    logic          row_closed;
    logic          db_done;
    logic          accept;
    logic [3:0]    code_d;

    // lowest-numbered low row wins
    always_comb begin
        any_hit = 1'b0;
        hit_row = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (!rows_n_i[r]) begin
                any_hit = 1'b1;
                hit_row = RW'(r);
            end
        end
    end

    assign row_closed = !rows_n_i[lock_row_q];
    assign db_done    = (cnt_q == DW'(DEBOUNCE_CYCLES - 1));
    assign run_o      = (state_q == ST_SCAN) && !(sample_i && any_hit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:     if (sample_i && any_hit) state_d = ST_DB_PRESS;
            ST_DB_PRESS: if (!row_closed)         state_d = ST_SCAN;
                         else if (db_done)        state_d = ST_HELD;
            ST_HELD:     if (!row_closed)         state_d = ST_DB_REL;
            ST_DB_REL:   if (row_closed)          state_d = ST_HELD;
                         else if (db_done)        state_d = ST_SCAN;
        endcase
    end

    assign accept = (state_q == ST_DB_PRESS) && (state_d == ST_HELD);

    always_comb begin
        int idx;
        idx    = int'(lock_row_q) * COLS + int'(col_idx_i);
        code_d = KEY_MAP[idx*4 +: 4];
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_SCAN;
            cnt_q      <= '0;
            lock_row_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q == ST_DB_PRESS || state_q == ST_DB_REL) begin
                cnt_q <= cnt_q + DW'(1);
            end
            if (state_q == ST_SCAN && sample_i && any_hit) begin
                lock_row_q <= hit_row;
            end
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_valid_o <= 1'b0;
            key_code_o  <= '0;
        end else begin
            key_valid_o <= accept;
            if (accept) key_code_o <= code_d;
        end
    end

    // R4: strobe lasts one clock
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    // R3: strobe only follows a completed press interval
    p_strobe_after_db_r3: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> (state_q == ST_HELD) && ($past(state_q) == ST_DB_PRESS));

    // R3: debounce counter stays within its interval
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DW'(DEBOUNCE_CYCLES - 1));

    // R6: no event while the lock persists
    p_held_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && $past(state_q) == ST_HELD) |-> !key_valid_o);

    // R7: scanning resumes only after a full open interval
    p_release_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) == ST_DB_REL)
            |-> $past(cnt_q) == DW'(DEBOUNCE_CYCLES - 1));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter int ROWS            = 4,
    parameter int COLS            = 4,
    parameter int SETTLE_CYCLES   = 4,
    parameter int DEBOUNCE_CYCLES = 1_000_000,
    parameter logic [ROWS*COLS*4-1:0] KEY_MAP = 64'hDF0E_C987_B654_A321
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_n_i,
    output logic [COLS-1:0] col_n_o,
    output logic            key_valid_o,
    output logic [3:0]      key_code_o
);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

    logic [ROWS-1:0] rows_s;
    logic [CW-1:0]   col_idx;
    logic            sample;
    logic            scan_run;

    kps_sync #(.WIDTH(ROWS), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (row_n_i),
        .q_o   (rows_s)
    );

    kps_col_scan #(.COLS(COLS), .SETTLE_CYCLES(SETTLE_CYCLES)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (scan_run),
        .col_idx_o (col_idx),
        .sample_o  (sample)
    );

    kps_ctrl #(
        .ROWS            (ROWS),
        .COLS            (COLS),
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
        .KEY_MAP         (KEY_MAP)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rows_n_i    (rows_s),
        .col_idx_i   (col_idx),
        .sample_i    (sample),
        .run_o       (scan_run),
        .key_valid_o (key_valid_o),
        .key_code_o  (key_code_o)
    );

    assign col_n_o = ~(COLS'(1) << col_idx);

    // R2: exactly one column driven
    p_one_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_n_o) == 1);
endmodule

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 16;
    localparam int SETTLE     = 4;
    localparam int NVEC       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  row_n;
    logic [3:0]  col_n;
    logic        valid;
    logic [3:0]  code;
    logic [15:0] keys = '0;   // index row*4+col

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic [3:0] last_code = '0;

    // vector: key index, hold cycles, expected code
    localparam int VKEY  [NVEC] = '{0, 3, 6, 9, 12, 13, 15, 11};
    localparam int VHOLD [NVEC] = '{60, 500, 90, 70, 300, 65, 120, 80};
    localparam logic [3:0] VCODE [NVEC] =
        '{4'h1, 4'hA, 4'h6, 4'h8, 4'hE, 4'h0, 4'hD, 4'hC};

    always #(CLK_PERIOD/2) clk = ~clk;

    keypad_scanner #(
        .SETTLE_CYCLES   (SETTLE),
        .DEBOUNCE_CYCLES (DEB)
    ) u_keypad_scanner (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_n_i     (row_n),
        .col_n_o     (col_n),
        .key_valid_o (valid),
        .key_code_o  (code)
    );

    // keypad model: closed key shorts its row to its column
    always_comb begin
        for (int r = 0; r < 4; r++) begin
            row_n[r] = ~|(keys[r*4 +: 4] & ~col_n);
        end
    end

    always @(posedge clk) begin
        if (valid) begin
            strobes   = strobes + 1;
            last_code = code;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle_out();
        wait_cyc(2*DEB + 40);
    endtask

    initial begin
        int base;
        int bad;
        @(negedge clk);
        wait_cyc(4);
        check(col_n == 4'b1110, "R1 reset column", col_n, 4'hE);
        check(valid == 1'b0,    "R1 reset strobe", valid, 0);
        check(code == 4'h0,     "R1 reset code",   code, 0);
        rst_n = 1'b1;

        // R2: scan order and pace
        bad = 0;
        for (int k = 0; k < 4*SETTLE*2; k++) begin
            if (col_n != ~(4'b0001 << ((k / SETTLE) % 4))) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R2 scan sequence mismatches", bad, 0);

        // R4/R5: table of clean presses
        for (int v = 0; v < NVEC; v++) begin
            base = strobes;
            keys[VKEY[v]] = 1'b1;
            wait_cyc(VHOLD[v]);
            keys[VKEY[v]] = 1'b0;
            settle_out();
            check(strobes - base == 1, "R5 one strobe per press", strobes - base, 1);
            check(last_code == VCODE[v], "R4 key code", last_code, VCODE[v]);
        end

        // R3: chattering contact never settles
        base = strobes;
        for (int i = 0; i < 10; i++) begin
            keys[7] = 1'b1; wait_cyc(5);
            keys[7] = 1'b0; wait_cyc(5);
        end
        settle_out();
        check(strobes == base, "R3 chatter rejected", strobes - base, 0);

        // R5: bounce at make, mid-hold and break
        base = strobes;
        for (int i = 0; i < 5; i++) begin
            keys[10] = 1'b1; wait_cyc(3);
            keys[10] = 1'b0; wait_cyc(3);
        end
        keys[10] = 1'b1; wait_cyc(150);
        keys[10] = 1'b0; wait_cyc(4);
        keys[10] = 1'b1; wait_cyc(150);
        for (int i = 0; i < 5; i++) begin
            keys[10] = 1'b0; wait_cyc(3);
            keys[10] = 1'b1; wait_cyc(3);
        end
        keys[10] = 1'b0;
        settle_out();
        check(strobes - base == 1, "R5 bouncy press count", strobes - base, 1);
        check(last_code == 4'h9, "R5 bouncy press code", last_code, 9);

        // R6: lock on row1 col1, add same-row and same-column keys
        base = strobes;
        keys[5] = 1'b1; wait_cyc(80);
        check(strobes - base == 1 && last_code == 4'h5, "R6 locked key reported", last_code, 5);
        keys[6] = 1'b1; keys[9] = 1'b1;
        bad = 0;
        for (int i = 0; i < 100; i++) begin
            if (col_n != 4'b1101) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R6 column frozen while held", bad, 0);
        keys[6] = 1'b0; keys[9] = 1'b0; wait_cyc(20);
        keys[5] = 1'b0;
        settle_out();
        check(strobes - base == 1, "R6 other keys ignored", strobes - base, 1);

        // R7: short opening then reclose gives no new event
        base = strobes;
        keys[1] = 1'b1; wait_cyc(80);
        keys[1] = 1'b0; wait_cyc(DEB/2);
        keys[1] = 1'b1; wait_cyc(80);
        keys[1] = 1'b0;
        settle_out();
        check(strobes - base == 1, "R7 short opening not a release", strobes - base, 1);
        base = strobes;
        keys[1] = 1'b1; wait_cyc(80);
        keys[1] = 1'b0;
        settle_out();
        check(strobes - base == 1 && last_code == 4'h2, "R7 press after full release", last_code, 2);

        // R8: two rows under column 0
        base = strobes;
        keys[4] = 1'b1; keys[12] = 1'b1; wait_cyc(80);
        keys[4] = 1'b0; keys[12] = 1'b0;
        settle_out();
        check(strobes - base == 1 && last_code == 4'h4, "R8 lowest row wins", last_code, 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL all watchdog actual %0d expected %0d", 100000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule